// File: doc/BRIEF.md
# Time-of-Year Calendar Counter

This block keeps wall-clock calendar time in a slow 32.768 kHz domain and presents it to software through a small register window in the bus clock domain. A programmable trim value divides the slow clock to make one tick per second. Each tick advances a packed calendar word that holds seconds, minutes, hours, day of month and month. The full four-digit year is held in a separate word, and the calendar follows month lengths and the leap-year rules.

Software sets the time by writing the calendar word and the year word, and changes the tick rate by writing the trim value. Each such write has to cross into the slow domain. While it does, a busy bit in the control/status word stays set, and software polls that bit before it issues the next write of the same kind. Reading the calendar word also captures the year into a shadow register, so the year read that follows matches the time just returned, even if a tick in between carried the year.

The registers for match and alarm are not built. Their addresses and every other unmapped address read as zero.

Top module: `toy_clock`

## Requirements
- R1: After reset the calendar word reads 0x04200000 (January 1, 00:00:00), the year reads 2000, the trim reads 32767, and control/status (offset 0x20) reads 0x00000120.
- R2: A write to offset 0x04 loads the calendar word. The fields are seconds in bits 9:4, minutes in 15:10, hours in 20:16, day in 25:21 and month (1-based) in 31:26. A read of offset 0x0C returns this word with bits 3:0 forced to zero.
- R3: A write to offset 0x08 loads the full year value, for example 2024. The year can be read at offset 0x10 after a calendar read.
- R4: A write to offset 0x04 or 0x08 sets status bit 0. The bit clears only after the value has reached the slow-domain counter. From that point a calendar or year read returns the new value.
- R5: While status bit 0 is set, further writes to offsets 0x04 and 0x08 are ignored.
- R6: A write to the trim register (offset 0x00) sets status bit 4 until the new trim is in effect. Trim writes made while bit 4 is set are ignored. Offset 0x00 reads back the accepted trim.
- R7: The seconds tick occurs every trim+1 cycles of the 32.768 kHz clock. Loading a new calendar value, year or trim restarts the count.
- R8: On each tick, seconds run 0–59, minutes 0–59 and hours 0–23, and each wraps to 0 with a carry into the next field.
- R9: The day wraps to 1 after the last day of the month: 30 days for months 4, 6, 9 and 11, 31 days for the other months, and 28 or 29 for February. A year is a leap year if it is divisible by 4, except that a year divisible by 100 is a leap year only if it is also divisible by 400.
- R10: Month 12 wraps to month 1, and the year increments by one.
- R11: A read of offset 0x10 returns the year captured by the most recent read of offset 0x0C, not the live year.
- R12: Reads of offsets 0x14, 0x18, 0x1C and of any unmapped offset return zero, and writes to those offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; at least six times the slow clock |
| clk32_i | input | 1 | 32.768 kHz counting clock |
| rst_ni | input | 1 | Synchronous active-low reset, held for at least three slow-clock edges |
| bus_addr_i | input | ADDR_W | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe, one bus cycle |
| bus_rd_i | input | 1 | Read strobe; data appears on the next bus cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered and held until the next read |

## Verification
The bound checker watches several properties on every clock edge. It checks that a pending write holds its staged value against later writes, and that a busy bit rises only after a matching write. It also checks that calendar reads return zero in the low nibble, that match offsets read zero, that the seconds field wraps after 59, and that two ticks never fall on adjacent slow cycles. Some behaviour can only be shown by the bench's scenarios, which drive real time through the clock crossing. These cover the measured tick spacing for two trim values, the carries at month ends, the leap-year rules in 1900, 2000, 2023 and 2024, the year carry from December, and a stale shadow year after a rollover.

// File: rtl/toy_pkg.sv
// Shared field widths, register offsets, the calendar record and the date
// helpers. Assumes byte addressing with 32-bit registers.
package toy_pkg;

    localparam int BUS_W     = 32;
    localparam int YEAR_W    = 32;
    localparam int SEC_W     = 6;
    localparam int MIN_W     = 6;
    localparam int HR_W      = 5;
    localparam int DAY_W     = 5;
    localparam int MON_W     = 6;
    localparam int FIELD_LSB = 4;
    localparam int CAL_W     = SEC_W + MIN_W + HR_W + DAY_W + MON_W;

    localparam logic [5:0] ADR_TRIM = 6'h00;
    localparam logic [5:0] ADR_TSET = 6'h04;
    localparam logic [5:0] ADR_YSET = 6'h08;
    localparam logic [5:0] ADR_TGET = 6'h0C;
    localparam logic [5:0] ADR_YGET = 6'h10;
    localparam logic [5:0] ADR_CTRL = 6'h20;

    localparam int ST_TSET_BUSY = 0;
    localparam int ST_TRIM_BUSY = 4;
    localparam int ST_OSC_OK    = 5;
    localparam int ST_RUN       = 8;

    // Packed so that the first member lands in the highest word bits
    typedef struct packed {
        logic [MON_W-1:0] mon;
        logic [DAY_W-1:0] day;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } cal_t;

    // Gregorian leap rule
    function automatic logic is_leap(input logic [YEAR_W-1:0] y);
        return (y[1:0] == 2'b00) && (((y % 100) != 0) || ((y % 400) == 0));
    endfunction

    // Days in a 1-based month
    function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m,
                                                   input logic leap);
        logic [DAY_W-1:0] d;
        case (m)
            MON_W'(2):  d = leap ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): d = DAY_W'(30);
            default:    d = DAY_W'(31);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/toy_xfer_chan.sv
// Moves one staged value from the bus domain into the slow domain with a
// toggle request and a toggle acknowledge, each passed through flop
// synchronisers. Assumes that the value stays in hold_o while busy_o is set,
// so the slow side may sample it freely during its load pulse.
module toy_xfer_chan #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter int          SYNC_N  = 3
) (
    input  logic         clk_i,
    input  logic         clk32_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] data_i,
    output logic         busy_o,
    output logic [W-1:0] hold_o,
    output logic         load_o
);

    logic              req_t;
    logic [SYNC_N-1:0] req_s;
    logic [SYNC_N-1:0] ack_s;

    assign busy_o = req_t ^ ack_s[SYNC_N-1];

    // Stage an accepted write and flip the request toggle
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            req_t  <= 1'b0;
            hold_o <= RST_VAL;
        end else if (start_i && !busy_o) begin
            req_t  <= ~req_t;
            hold_o <= data_i;
        end
    end

    // Bring the acknowledge (last slow sync stage) back to the bus domain
    always_ff @(posedge clk_i) begin
        if (!rst_ni) ack_s <= '0;
        else         ack_s <= {ack_s[SYNC_N-2:0], req_s[SYNC_N-1]};
    end

    // Synchronise the request into the slow domain
    always_ff @(posedge clk32_i) begin
        if (!rst_ni) req_s <= '0;
        else         req_s <= {req_s[SYNC_N-2:0], req_t};
    end

    assign load_o = req_s[SYNC_N-2] ^ req_s[SYNC_N-1];

endmodule

// File: rtl/toy_prescaler.sv
// Divides the slow clock by trim+1 to make the seconds tick. Holds its own
// copy of the trim value. Assumes clr_i accompanies every trim load.
module toy_prescaler #(
    parameter int               TRIM_W   = 16,
    parameter logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(32767)
) (
    input  logic              clk32_i,
    input  logic              rst_ni,
    input  logic              ld_trim_i,
    input  logic [TRIM_W-1:0] trim_i,
    input  logic              clr_i,
    output logic              tick_o,
    output logic [TRIM_W-1:0] trim_o
);

    logic [TRIM_W-1:0] cnt_q;

    assign tick_o = (cnt_q == trim_o);

    // Hold the active trim value
    always_ff @(posedge clk32_i) begin
        if (!rst_ni)        trim_o <= TRIM_RST;
        else if (ld_trim_i) trim_o <= trim_i;
    end

    // Count slow cycles, restarting on a tick or a clear
    always_ff @(posedge clk32_i) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (clr_i || tick_o) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/toy_calendar.sv
// Slow-domain calendar: seconds through month, plus the full year. A load
// takes priority over a tick in the same cycle. upd_o toggles on every
// change so the bus side knows when to copy. Loaded values are not checked.
module toy_calendar
    import toy_pkg::*;
#(
    parameter int RST_YEAR = 2000
) (
    input  logic              clk32_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              ld_time_i,
    input  logic              ld_year_i,
    input  cal_t              time_i,
    input  logic [YEAR_W-1:0] year_i,
    output cal_t              cal_o,
    output logic [YEAR_W-1:0] year_o,
    output logic              upd_o
);

    cal_t              nxt;
    logic [YEAR_W-1:0] nyr;
    logic [DAY_W-1:0]  mlen;
    logic              step;

    assign mlen = month_len(cal_o.mon, is_leap(year_o));
    assign step = tick_i && !ld_time_i && !ld_year_i;

    // Successor of the current date with the carry chain
    always_comb begin
        nxt = cal_o;
        nyr = year_o;
        if (cal_o.sec >= SEC_W'(59)) begin
            nxt.sec = '0;
            if (cal_o.min >= MIN_W'(59)) begin
                nxt.min = '0;
                if (cal_o.hr >= HR_W'(23)) begin
                    nxt.hr = '0;
                    if (cal_o.day >= mlen) begin
                        nxt.day = DAY_W'(1);
                        if (cal_o.mon >= MON_W'(12)) begin
                            nxt.mon = MON_W'(1);
                            nyr     = year_o + 1'b1;
                        end else begin
                            nxt.mon = cal_o.mon + 1'b1;
                        end
                    end else begin
                        nxt.day = cal_o.day + 1'b1;
                    end
                end else begin
                    nxt.hr = cal_o.hr + 1'b1;
                end
            end else begin
                nxt.min = cal_o.min + 1'b1;
            end
        end else begin
            nxt.sec = cal_o.sec + 1'b1;
        end
    end

    // Calendar fields: load or advance
    always_ff @(posedge clk32_i) begin
        if (!rst_ni) begin
            cal_o <= '{mon: MON_W'(1), day: DAY_W'(1), hr: '0, min: '0, sec: '0};
        end else if (ld_time_i) begin
            cal_o <= time_i;
        end else if (step) begin
            cal_o <= nxt;
        end
    end

    // Year register: load or carry from December
    always_ff @(posedge clk32_i) begin
        if (!rst_ni)        year_o <= YEAR_W'(RST_YEAR);
        else if (ld_year_i) year_o <= year_i;
        else if (step)      year_o <= nyr;
    end

    // Change toggle for the bus-side copy
    always_ff @(posedge clk32_i) begin
        if (!rst_ni)                           upd_o <= 1'b0;
        else if (ld_time_i || ld_year_i || tick_i) upd_o <= ~upd_o;
    end

endmodule

// File: rtl/toy_mirror.sv
// Bus-domain copy of the calendar and year. It copies when the synchronised
// change toggle flips. Assumes the slow registers hold still for at least
// one slow period after a change, and the bus clock is at least six times
// faster, so the copy is taken while the source is stable.
module toy_mirror
    import toy_pkg::*;
#(
    parameter int RST_YEAR = 2000,
    parameter int SYNC_N   = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              upd_i,
    input  cal_t              cal_i,
    input  logic [YEAR_W-1:0] year_i,
    output cal_t              cal_o,
    output logic [YEAR_W-1:0] year_o
);

    logic [SYNC_N-1:0] upd_s;
    logic              grab;

    assign grab = upd_s[SYNC_N-2] ^ upd_s[SYNC_N-1];

    // Synchronise the change toggle
    always_ff @(posedge clk_i) begin
        if (!rst_ni) upd_s <= '0;
        else         upd_s <= {upd_s[SYNC_N-2:0], upd_i};
    end

    // Copy the slow registers once the toggle has settled
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cal_o  <= '{mon: MON_W'(1), day: DAY_W'(1), hr: '0, min: '0, sec: '0};
            year_o <= YEAR_W'(RST_YEAR);
        end else if (grab) begin
            cal_o  <= cal_i;
            year_o <= year_i;
        end
    end

endmodule

// File: rtl/toy_clock.sv
// Time-of-year counter top: register decode, read mux and year shadow in the
// bus domain; prescaler and calendar in the slow domain. Both domains use the
// same synchronous active-low reset, held over several slow edges.
module toy_clock
    import toy_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int TRIM_W   = 16,
    parameter int TRIM_RST = 32767,
    parameter int RST_YEAR = 2000,
    parameter int SYNC_N   = 3
) (
    input  logic              clk_i,
    input  logic              clk32_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o
);

    localparam int TSET_W = BUS_W + 1;

    logic              is_tset, is_yset, wr_tset, wr_trim;
    logic              tset_busy, trim_busy;
    logic [TSET_W-1:0] tset_hold;
    logic [TRIM_W-1:0] trim_hold, trim_cur;
    logic              tset_load, ld_time, ld_year, ld_trim, tick;
    cal_t              cal_cur, cal_m;
    logic [YEAR_W-1:0] year_cur, year_m, year_shadow;
    logic              upd_t;
    logic [BUS_W-1:0]  status;

    assign is_tset = (bus_addr_i == ADDR_W'(ADR_TSET));
    assign is_yset = (bus_addr_i == ADDR_W'(ADR_YSET));
    assign wr_tset = bus_wr_i && (is_tset || is_yset);
    assign wr_trim = bus_wr_i && (bus_addr_i == ADDR_W'(ADR_TRIM));

    toy_xfer_chan #(.W(TSET_W), .RST_VAL('0), .SYNC_N(SYNC_N)) u_tset (
        .clk_i  (clk_i),
        .clk32_i(clk32_i),
        .rst_ni (rst_ni),
        .start_i(wr_tset),
        .data_i ({is_yset, bus_wdata_i}),
        .busy_o (tset_busy),
        .hold_o (tset_hold),
        .load_o (tset_load)
    );

    toy_xfer_chan #(.W(TRIM_W), .RST_VAL(TRIM_W'(TRIM_RST)), .SYNC_N(SYNC_N)) u_trim (
        .clk_i  (clk_i),
        .clk32_i(clk32_i),
        .rst_ni (rst_ni),
        .start_i(wr_trim),
        .data_i (bus_wdata_i[TRIM_W-1:0]),
        .busy_o (trim_busy),
        .hold_o (trim_hold),
        .load_o (ld_trim)
    );

    assign ld_year = tset_load && tset_hold[TSET_W-1];
    assign ld_time = tset_load && !tset_hold[TSET_W-1];

    toy_prescaler #(.TRIM_W(TRIM_W), .TRIM_RST(TRIM_W'(TRIM_RST))) u_pre (
        .clk32_i  (clk32_i),
        .rst_ni   (rst_ni),
        .ld_trim_i(ld_trim),
        .trim_i   (trim_hold),
        .clr_i    (ld_trim || tset_load),
        .tick_o   (tick),
        .trim_o   (trim_cur)
    );

    toy_calendar #(.RST_YEAR(RST_YEAR)) u_cal (
        .clk32_i  (clk32_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .ld_time_i(ld_time),
        .ld_year_i(ld_year),
        .time_i   (cal_t'(tset_hold[BUS_W-1:FIELD_LSB])),
        .year_i   (tset_hold[YEAR_W-1:0]),
        .cal_o    (cal_cur),
        .year_o   (year_cur),
        .upd_o    (upd_t)
    );

    toy_mirror #(.RST_YEAR(RST_YEAR), .SYNC_N(SYNC_N)) u_mir (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .upd_i (upd_t),
        .cal_i (cal_cur),
        .year_i(year_cur),
        .cal_o (cal_m),
        .year_o(year_m)
    );

    // Control/status word: two busy bits and two fixed running bits
    always_comb begin
        status               = '0;
        status[ST_TSET_BUSY] = tset_busy;
        status[ST_TRIM_BUSY] = trim_busy;
        status[ST_OSC_OK]    = 1'b1;
        status[ST_RUN]       = 1'b1;
    end

    // Registered read mux; a calendar read also captures the year shadow
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bus_rdata_o <= '0;
            year_shadow <= YEAR_W'(RST_YEAR);
        end else if (bus_rd_i) begin
            case (bus_addr_i)
                ADDR_W'(ADR_TRIM): bus_rdata_o <= BUS_W'(trim_hold);
                ADDR_W'(ADR_TGET): begin
                    bus_rdata_o <= {cal_m, {FIELD_LSB{1'b0}}};
                    year_shadow <= year_m;
                end
                ADDR_W'(ADR_YGET): bus_rdata_o <= year_shadow;
                ADDR_W'(ADR_CTRL): bus_rdata_o <= status;
                default:           bus_rdata_o <= '0;
            endcase
        end
    end

endmodule

// File: rtl/toy_clock_chk.sv
// Property checker for toy_clock, attached with bind. Watches the staging
// registers, the read port and the slow-domain tick and seconds field.
module toy_clock_chk
    import toy_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int TRIM_W = 16
) (
    input logic              clk_i,
    input logic              clk32_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [BUS_W-1:0]  bus_rdata_o,
    input logic              tset_busy,
    input logic [BUS_W:0]    tset_hold,
    input logic              trim_busy,
    input logic [TRIM_W-1:0] trim_hold,
    input logic [TRIM_W-1:0] trim_cur,
    input logic              tick,
    input logic              ld_time,
    input logic              ld_year,
    input logic              ld_trim,
    input logic [CAL_W-1:0]  cal_cur
);

    logic a_tset, a_trim, a_tget, a_match;
    assign a_tset  = (bus_addr_i == ADDR_W'(ADR_TSET)) || (bus_addr_i == ADDR_W'(ADR_YSET));
    assign a_trim  = (bus_addr_i == ADDR_W'(ADR_TRIM));
    assign a_tget  = (bus_addr_i == ADDR_W'(ADR_TGET));
    assign a_match = (bus_addr_i == ADDR_W'(6'h14)) || (bus_addr_i == ADDR_W'(6'h18)) ||
                     (bus_addr_i == ADDR_W'(6'h1C));

    // R5
    tset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tset_busy && bus_wr_i && a_tset) |=> $stable(tset_hold));

    // R6
    trim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trim_busy && bus_wr_i && a_trim) |=> $stable(trim_hold));

    // R4
    tset_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tset_busy) |-> $past(bus_wr_i && a_tset));

    // R6
    trim_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(trim_busy) |-> $past(bus_wr_i && a_trim));

    // R2
    low_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && a_tget) |=> (bus_rdata_o[FIELD_LSB-1:0] == '0));

    // R12
    match_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && a_match) |=> (bus_rdata_o == '0));

    // R8
    sec_wrap_chk: assert property (@(posedge clk32_i) disable iff (!rst_ni)
        (tick && !ld_time && !ld_year && (cal_cur[SEC_W-1:0] >= SEC_W'(59)))
        |=> (cal_cur[SEC_W-1:0] == '0));

    // R7
    tick_gap_chk: assert property (@(posedge clk32_i) disable iff (!rst_ni)
        (tick && !ld_trim && (trim_cur != '0)) |=> !tick);

endmodule

bind toy_clock toy_clock_chk #(.ADDR_W(ADDR_W), .TRIM_W(TRIM_W)) u_chk (
    .clk_i      (clk_i),
    .clk32_i    (clk32_i),
    .rst_ni     (rst_ni),
    .bus_addr_i (bus_addr_i),
    .bus_wr_i   (bus_wr_i),
    .bus_rd_i   (bus_rd_i),
    .bus_rdata_o(bus_rdata_o),
    .tset_busy  (tset_busy),
    .tset_hold  (tset_hold),
    .trim_busy  (trim_busy),
    .trim_hold  (trim_hold),
    .trim_cur   (trim_cur),
    .tick       (tick),
    .ld_time    (ld_time),
    .ld_year    (ld_year),
    .ld_trim    (ld_trim),
    .cal_cur    (cal_cur)
);

// File: tb/sim_toy_clock.sv
// Directed bench for toy_clock: one task per scenario, each checking itself.
module sim_toy_clock;

    localparam int BUS_PER  = 10;
    localparam int SLOW_PER = 100;

    logic        clk = 1'b0;
    logic        clk32 = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int nvec = 0;
    int nfail = 0;

    always #(BUS_PER/2) clk = ~clk;
    always #(SLOW_PER/2) clk32 = ~clk32;

    toy_clock u0 (
        .clk_i(clk), .clk32_i(clk32), .rst_ni(rst_n),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata)
    );

    function automatic logic [31:0] pk(input int mo, input int d, input int h,
                                       input int mi, input int s);
        return (32'(mo) << 26) | (32'(d) << 21) | (32'(h) << 16) |
               (32'(mi) << 10) | (32'(s) << 4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic wait_idle(input string req, input logic [31:0] mask);
        logic [31:0] v;
        bit done = 0;
        for (int i = 0; i < 2000 && !done; i++) begin
            bus_read(6'h20, v);
            done = ((v & mask) == 0);
        end
        if (!done) begin
            nvec++; nfail++;
            $display("FAIL %s actual=busy expected=idle", req);
        end
    endtask

    task automatic set_date(input logic [31:0] t, input int y);
        bus_write(6'h04, t);
        wait_idle("R4", 32'h1);
        bus_write(6'h08, 32'(y));
        wait_idle("R4", 32'h1);
    endtask

    // Poll the calendar word until it changes from prev
    task automatic wait_change(input logic [31:0] prev, output logic [31:0] v);
        v = prev;
        for (int i = 0; i < 5000 && v == prev; i++) bus_read(6'h0C, v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(6'h0C, v); chk("R1 time", v, 32'h04200000);
        bus_read(6'h10, v); chk("R1 year", v, 32'd2000);
        bus_read(6'h00, v); chk("R1 trim", v, 32'd32767);
        bus_read(6'h20, v); chk("R1 status", v, 32'h00000120);
    endtask

    task automatic t_load();
        logic [31:0] v;
        bus_write(6'h04, pk(6, 15, 10, 20, 30) | 32'hF);
        bus_read(6'h20, v); chk("R4 busy set", v & 32'h1, 32'h1);
        wait_idle("R4", 32'h1);
        bus_write(6'h08, 32'd2024);
        wait_idle("R4", 32'h1);
        bus_read(6'h0C, v); chk("R2 load", v, pk(6, 15, 10, 20, 30));
        bus_read(6'h10, v); chk("R3 year", v, 32'd2024);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_write(6'h14, 32'hFFFF_FFFF);
        bus_write(6'h18, 32'hFFFF_FFFF);
        bus_write(6'h20, 32'hFFFF_FFFF);
        bus_read(6'h14, v); chk("R12 m0", v, 32'h0);
        bus_read(6'h18, v); chk("R12 m1", v, 32'h0);
        bus_read(6'h1C, v); chk("R12 m2", v, 32'h0);
        bus_read(6'h3C, v); chk("R12 unmapped", v, 32'h0);
        bus_read(6'h20, v); chk("R12 status", v, 32'h00000120);
        bus_read(6'h0C, v); chk("R12 time", v, pk(6, 15, 10, 20, 30));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        bus_write(6'h04, pk(7, 4, 12, 0, 0));
        bus_write(6'h04, pk(8, 9, 1, 2, 3));
        bus_write(6'h08, 32'd1999);
        wait_idle("R5", 32'h1);
        bus_read(6'h0C, v); chk("R5 time", v, pk(7, 4, 12, 0, 0));
        bus_read(6'h10, v); chk("R5 year", v, 32'd2024);
    endtask

    task automatic t_trim();
        logic [31:0] v;
        bus_write(6'h00, 32'd15);
        bus_write(6'h00, 32'd9);
        bus_read(6'h20, v); chk("R6 busy set", v & 32'h10, 32'h10);
        wait_idle("R6", 32'h10);
        bus_read(6'h00, v); chk("R6 trim", v, 32'd15);
    endtask

    task automatic t_rate(input int trimv, input int exp_t);
        logic [31:0] v0, v;
        longint t1, t2, diff;
        bus_write(6'h00, 32'(trimv));
        wait_idle("R7", 32'h10);
        bus_read(6'h0C, v0);
        wait_change(v0, v); t1 = $time;
        v0 = v;
        wait_change(v0, v); t2 = $time;
        diff = t2 - t1;
        nvec++;
        if (diff < exp_t - 30 || diff > exp_t + 30) begin
            nfail++;
            $display("FAIL R7 tick spacing actual=%0d expected=%0d", diff, exp_t);
        end
    endtask

    task automatic t_step(input string req, input logic [31:0] t, input int y,
                          input logic [31:0] et, input int ey);
        logic [31:0] v0, v, yv;
        set_date(t, y);
        bus_read(6'h0C, v0);
        chk({req, " loaded"}, v0, t);
        wait_change(v0, v);
        bus_read(6'h10, yv);
        chk({req, " next"}, v, et);
        chk({req, " year"}, yv, 32'(ey));
    endtask

    task automatic t_shadow();
        logic [31:0] v;
        set_date(pk(12, 31, 23, 59, 59), 2030);
        bus_read(6'h0C, v);
        #(2500);
        bus_read(6'h10, v); chk("R11 stale year", v, 32'd2030);
        bus_read(6'h0C, v); chk("R11 time", v, pk(1, 1, 0, 0, 0));
        bus_read(6'h10, v); chk("R11 new year", v, 32'd2031);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #(BUS_PER * 150000);
        nvec++; nfail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (40) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_load();
        t_unmapped();
        t_busy_ignore();
        t_trim();
        t_rate(15, 16 * SLOW_PER);
        t_rate(7, 8 * SLOW_PER);
        t_rate(15, 16 * SLOW_PER);
        t_step("R8 sec",   pk(3, 10, 10, 20, 30), 2024, pk(3, 10, 10, 20, 31), 2024);
        t_step("R8 min",   pk(3, 10, 10, 20, 59), 2024, pk(3, 10, 10, 21, 0), 2024);
        t_step("R8 hour",  pk(3, 10, 10, 59, 59), 2024, pk(3, 10, 11, 0, 0), 2024);
        t_step("R8 day",   pk(3, 10, 23, 59, 59), 2024, pk(3, 11, 0, 0, 0), 2024);
        t_step("R9 apr",   pk(4, 30, 23, 59, 59), 2024, pk(5, 1, 0, 0, 0), 2024);
        t_step("R9 jan",   pk(1, 31, 23, 59, 59), 2024, pk(2, 1, 0, 0, 0), 2024);
        t_step("R9 f2024", pk(2, 28, 23, 59, 59), 2024, pk(2, 29, 0, 0, 0), 2024);
        t_step("R9 f29",   pk(2, 29, 23, 59, 59), 2024, pk(3, 1, 0, 0, 0), 2024);
        t_step("R9 f2023", pk(2, 28, 23, 59, 59), 2023, pk(3, 1, 0, 0, 0), 2023);
        t_step("R9 f1900", pk(2, 28, 23, 59, 59), 1900, pk(3, 1, 0, 0, 0), 1900);
        t_step("R9 f2000", pk(2, 28, 23, 59, 59), 2000, pk(2, 29, 0, 0, 0), 2000);
        t_step("R10 dec",  pk(12, 31, 23, 59, 59), 2099, pk(1, 1, 0, 0, 0), 2100);
        t_shadow();
        finish_run();
    end

endmodule